// File: doc/BRIEF.md
# Incremental Conversion Sequencer with Offset Chopping

This block runs the digital side of one incremental conversion. Each cycle of `clk` is one slow modulator period. A `start` pulse given while the block is idle begins a conversion of N periods, numbered 0 to N-1. During period 0 the first integrator is kept in reset. The second integrator is already running, because in that period it receives the input through the feedforward path. From period 1 onward both integrators run. When the last period is over, the block raises a one-cycle end-of-conversion pulse. It then holds both integrators in reset until the next start.

The block also drives the chopper polarity of the first amplifier. The chopper swaps that amplifier's input and output together, which cancels the amplifier's offset. In internal mode the polarity starts non-inverted. It inverts at a programmable period index. When the second flip is enabled, it returns to non-inverted at a later programmable index. In external mode a pin sets the polarity directly, so a foreground calibration routine can choose the flip times. The period count, the two flip indices and the second-flip enable are captured at start.

Top module: `incr_conv_seq`

## Requirements
- R1: After reset, and whenever no conversion is running, `int1_rst` and `int2_rst` are 1, `chop_pol` is 0, `period_idx` is 0 and `eoc` is 0.
- R2: A `start` seen at a clock edge while idle begins a conversion. In the next cycle `period_idx` is 0, and it then rises by one per cycle up to N-1. A `num_periods` of 0 acts as 1.
- R3: During a conversion, `int1_rst` is 1 in period 0 and 0 in every later period. `int2_rst` is 0 in every period of the conversion.
- R4: In the cycle after period N-1, `eoc` is 1 for exactly one cycle and the block is idle in that cycle.
- R5: In internal mode (`ext_chop_sel`=0), `chop_pol` is 0 in period 0. It is 1 in every period p with p >= K1, where K1 is `flip_a`, provided 1 <= K1 < N. Otherwise the first flip is ignored.
- R6: With `dual_flip_en`=1, the polarity inverts a second time from period K2 (`flip_b`) onward, provided K1 < K2 < N. Otherwise the second flip is ignored. With `dual_flip_en`=0, K2 has no effect.
- R7: With `ext_chop_sel`=1, `chop_pol` equals `ext_chop_in` in every period of a conversion, and it is 0 when idle.
- R8: `num_periods`, `flip_a`, `flip_b` and `dual_flip_en` are sampled at start. Changing them during a conversion does not change its length or its polarity pattern.
- R9: A `start` during a running conversion is ignored. The period count continues without a restart.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Slow period clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a conversion when idle |
| num_periods | input | CNT_W | Conversion length N |
| flip_a | input | CNT_W | First flip period index K1 |
| flip_b | input | CNT_W | Second flip period index K2 |
| dual_flip_en | input | 1 | Enable the second flip |
| ext_chop_sel | input | 1 | Select pin-driven chopper polarity |
| ext_chop_in | input | 1 | External chopper polarity |
| int1_rst | output | 1 | First integrator reset |
| int2_rst | output | 1 | Second integrator reset |
| chop_pol | output | 1 | Chopper polarity, 1 = inverted |
| period_idx | output | CNT_W | Current period index |
| eoc | output | 1 | End of conversion pulse |

## Verification
Internal mode is swept over every combination of N from 0 to 6, both flip indices from 0 to 7, and both settings of the second-flip enable. These include indices of 0, indices equal to or beyond N, and second indices at or below the first. A wrong bound on a flip index, or an off-by-one flip period, therefore shows up at a specific period. Separate runs toggle the external pin, change the configuration mid-conversion, and pulse start mid-conversion. These runs distinguish live from captured settings and separate restart from ignore behaviour.

// File: rtl/incr_conv_seq.sv
module incr_conv_seq #(
  parameter int CNT_W = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [CNT_W-1:0] num_periods,
  input  logic [CNT_W-1:0] flip_a,
  input  logic [CNT_W-1:0] flip_b,
  input  logic             dual_flip_en,
  input  logic             ext_chop_sel,
  input  logic             ext_chop_in,
  output logic             int1_rst,
  output logic             int2_rst,
  output logic             chop_pol,
  output logic [CNT_W-1:0] period_idx,
  output logic             eoc
);

  logic             busy;
  logic [CNT_W-1:0] n_q, ka_q, kb_q;
  logic             dual_q;

  wire [CNT_W-1:0] last_p = (n_q == '0) ? '0 : n_q - 1'b1;
  wire             at_end = (period_idx >= last_p);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy       <= 1'b0;
      period_idx <= '0;
      eoc        <= 1'b0;
      n_q        <= '0;
      ka_q       <= '0;
      kb_q       <= '0;
      dual_q     <= 1'b0;
    end else begin
      eoc <= 1'b0;
      if (!busy) begin
        period_idx <= '0;
        if (start) begin
          busy   <= 1'b1;
          n_q    <= num_periods;
          ka_q   <= flip_a;
          kb_q   <= flip_b;
          dual_q <= dual_flip_en;
        end
      end else if (at_end) begin
        busy       <= 1'b0;
        period_idx <= '0;
        eoc        <= 1'b1;
      end else begin
        period_idx <= period_idx + 1'b1;
      end
    end
  end

  wire ka_ok = (ka_q != '0) && (ka_q < n_q);
  wire kb_ok = dual_q && (kb_q > ka_q) && (kb_q < n_q);
  wire int_chop = (ka_ok && period_idx >= ka_q) ^ (kb_ok && period_idx >= kb_q);

  assign chop_pol = busy & (ext_chop_sel ? ext_chop_in : int_chop);
  assign int1_rst = ~busy | (period_idx == '0);
  assign int2_rst = ~busy;

  // R4
  eoc_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    eoc |=> !eoc);
  // R4
  eoc_after_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(eoc) |-> (!busy && $past(busy)));
  // R3
  first_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> (!int1_rst && !int2_rst));
  // R2
  start_period_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> (period_idx == '0 && int1_rst && !int2_rst));
  // R2
  count_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> (period_idx == $past(period_idx) + 1'b1));
  // R1
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!chop_pol && period_idx == '0 && int1_rst && int2_rst));
  // R5
  chop_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(busy) && !ext_chop_sel) |-> !chop_pol);
  // R6
  chop_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy) && !ext_chop_sel && !$past(ext_chop_sel) && chop_pol != $past(chop_pol))
      |-> (period_idx == ka_q || period_idx == kb_q));

endmodule

// File: tb/test_incr_conv_seq.sv
module test_incr_conv_seq;
  localparam int W = 10;
  logic clk = 0, rst_n = 0, start = 0;
  logic [W-1:0] num_periods = 0, flip_a = 0, flip_b = 0;
  logic dual_flip_en = 0, ext_chop_sel = 0, ext_chop_in = 0;
  logic int1_rst, int2_rst, chop_pol, eoc;
  logic [W-1:0] period_idx;
  int checks = 0, fails = 0;

  always #10 clk = ~clk;

  incr_conv_seq #(.CNT_W(W)) i_incr_conv_seq (
    .clk(clk), .rst_n(rst_n), .start(start), .num_periods(num_periods),
    .flip_a(flip_a), .flip_b(flip_b), .dual_flip_en(dual_flip_en),
    .ext_chop_sel(ext_chop_sel), .ext_chop_in(ext_chop_in),
    .int1_rst(int1_rst), .int2_rst(int2_rst), .chop_pol(chop_pol),
    .period_idx(period_idx), .eoc(eoc));

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  function automatic int exp_chop(int n, int ka, int kb, int d, int p);
    int a, b;
    a = (ka >= 1 && ka < n && p >= ka) ? 1 : 0;
    b = (d != 0 && kb > ka && kb < n && p >= kb) ? 1 : 0;
    return a ^ b;
  endfunction

  task automatic check_idle(string req);
    chk({req, " int1_rst"}, int1_rst, 1);
    chk({req, " int2_rst"}, int2_rst, 1);
    chk({req, " chop_pol"}, chop_pol, 0);
    chk({req, " period_idx"}, period_idx, 0);
  endtask

  task automatic run(int n, int ka, int kb, int d, int mode);
    int ne;
    ne = (n == 0) ? 1 : n;
    @(negedge clk);
    num_periods = W'(n); flip_a = W'(ka); flip_b = W'(kb); dual_flip_en = d[0];
    start = 1;
    @(negedge clk);
    start = 0;
    if (mode == 1) begin
      num_periods = W'(n + 3); flip_a = 0; flip_b = 1; dual_flip_en = ~d[0];
    end
    for (int p = 0; p < ne; p++) begin
      if (mode == 2 && p == 2) start = 1;
      if (mode == 2 && p == 3) start = 0;
      chk("R2 period", period_idx, p);
      chk("R3 int1_rst", int1_rst, (p == 0) ? 1 : 0);
      chk("R3 int2_rst", int2_rst, 0);
      chk("R4 eoc low", eoc, 0);
      if (mode == 1) chk("R8 chop", chop_pol, exp_chop(n, ka, kb, d, p));
      else if (mode == 2) chk("R9 chop", chop_pol, exp_chop(n, ka, kb, d, p));
      else if (d != 0) chk("R6 chop", chop_pol, exp_chop(n, ka, kb, d, p));
      else chk("R5 chop", chop_pol, exp_chop(n, ka, kb, d, p));
      @(negedge clk);
    end
    start = 0;
    chk("R4 eoc", eoc, 1);
    check_idle("R1 after");
    @(negedge clk);
    chk("R4 eoc pulse", eoc, 0);
  endtask

  initial begin
    #1000000;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (2) @(negedge clk);
    check_idle("R1 reset");
    chk("R1 eoc", eoc, 0);
    rst_n = 1;
    @(negedge clk);
    check_idle("R1 idle");
    for (int n = 0; n <= 6; n++)
      for (int ka = 0; ka <= 7; ka++)
        for (int kb = 0; kb <= 7; kb++)
          for (int d = 0; d <= 1; d++)
            run(n, ka, kb, d, 0);
    run(6, 2, 4, 1, 1);
    run(5, 3, 0, 0, 1);
    run(8, 3, 6, 1, 2);
    // R7 external polarity
    @(negedge clk);
    ext_chop_sel = 1; ext_chop_in = 1;
    chk("R7 idle", chop_pol, 0);
    num_periods = 6; flip_a = 2; flip_b = 4; dual_flip_en = 1; start = 1;
    @(negedge clk);
    start = 0;
    for (int p = 0; p < 6; p++) begin
      ext_chop_in = (p % 3 != 1);
      #1;
      chk("R7 follow", chop_pol, (p % 3 != 1) ? 1 : 0);
      @(negedge clk);
    end
    chk("R7 eoc", eoc, 1);
    chk("R7 after", chop_pol, 0);
    ext_chop_sel = 0; ext_chop_in = 0;
    @(negedge clk);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule